// File: doc/BRIEF.md
# Flash Query Mode Controller

This block sits in the command path of a flash device. It decodes qualified bus writes and, when it sees the query command at the right address for the current bus width, switches the read path from the memory array to a small table of device details. The table holds the ASCII signature, the command set code, the supply voltage range, the device size as a power of two, and the bus organisation code.

While the block is in query mode, every read returns one table byte on the low eight data lines, and the upper eight lines read zero. Data coming from the array is not used while query mode lasts. A reset command (F0h at any address) or the hardware reset input returns the block to array reads.

The surrounding device qualifies the bus cycles. A write is presented as a one-cycle `wrEn` strobe. A read is combinational: the data follows the address with no clock edge in between.

Top module: `flash_query_mode`

## Requirements
- R1: After hardware reset, `queryActive` is 0 and `rdData` equals `arrayData`.
- R2: In word mode (`byteMode`=0), a write with `wrData[7:0]`=98h to address 55h sets `queryActive` on the next clock edge.
- R3: In byte mode (`byteMode`=1), a write with `wrData[7:0]`=98h to address AAh sets `queryActive` on the next clock edge.
- R4: A 98h write to any other address leaves `queryActive` at 0. This covers AAh in word mode and 55h in byte mode.
- R5: In query mode with `byteMode`=0, the table index equals `addr`. `rdData[7:0]` is the table byte and `rdData[15:8]` is 00h. The table holds: 10h=51h, 11h=52h, 12h=59h, 13h=02h, 1Bh=27h, 1Ch=36h, 27h=`SIZE_LOG2` (default 22 = 16h), 28h=02h. Every other index holds 00h.
- R6: In query mode with `byteMode`=1, the table index is `addr` shifted right by one, so `addr[0]` is ignored. `rdData[15:8]` is 00h.
- R7: In query mode, a table index at or above `TABLE_DEPTH` (default 64) reads 0000h.
- R8: A write with `wrData[7:0]`=F0h at any address clears `queryActive` on the next edge. After that, `rdData` equals `arrayData` again.
- R9: In query mode, a write whose low data byte is not F0h leaves the block in query mode.
- R10: Asserting `rstN` low clears query mode. The block stays in array mode after `rstN` is released.
- R11: Address and data presented with `wrEn` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| byteMode | input | 1 | 1 selects the x8 bus organisation, 0 selects x16 |
| wrEn | input | 1 | One-cycle qualified write strobe |
| addr | input | ADDR_W | Bus address |
| wrData | input | 16 | Write data; only bits 7..0 are decoded |
| arrayData | input | 16 | Data read from the memory array |
| queryActive | output | 1 | 1 while query mode is active |
| rdData | output | 16 | Read data returned to the bus |

## Verification
The block has a single bit of state: the query-mode flag. A wrong value of that flag shows at the ports one clock edge after the write that caused it. `queryActive` flips, and `rdData` switches between the array value and a table byte that has a zero upper lane. The bench makes the two sources easy to tell apart by holding a distinctive pattern on `arrayData`. A fault in index decoding is different: it does not change the mode. It shows up only as a wrong table byte on the very read that uses that index. For that reason the bench reads known entries, out-of-range indices and both halves of each byte-mode address pair.

// File: rtl/flash_query_pkg.sv
package flash_query_pkg;

  typedef struct packed {
    logic enterQuery;
    logic leaveQuery;
  } qmStrobe_t;

  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] WORD_ENTRY_ADDR = 8'h55;
  localparam logic [7:0] BYTE_ENTRY_ADDR = 8'hAA;

  // Query table contents; indices absent from the case read as zero.
  function automatic logic [7:0] queryByte(input int unsigned idx, input int unsigned sizeLog2);
    logic [7:0] val;
    case (idx)
      32'h10:  val = 8'h51;           // 'Q'
      32'h11:  val = 8'h52;           // 'R'
      32'h12:  val = 8'h59;           // 'Y'
      32'h13:  val = 8'h02;           // command set code
      32'h1B:  val = 8'h27;           // minimum supply, 2.7 V
      32'h1C:  val = 8'h36;           // maximum supply, 3.6 V
      32'h27:  val = 8'(sizeLog2);    // device size, 2^n bytes
      32'h28:  val = 8'h02;           // x8/x16 organisation code
      default: val = 8'h00;
    endcase
    return val;
  endfunction

endpackage

// File: rtl/flash_query_ctrl.sv
module flash_query_ctrl
  import flash_query_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              byteMode,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output qmStrobe_t         strb
);

  logic [ADDR_W-1:0] entryAddr;
  logic              isQueryCmd;
  logic              isResetCmd;

  // The entry address depends on the bus organisation.
  assign entryAddr  = byteMode ? ADDR_W'(BYTE_ENTRY_ADDR) : ADDR_W'(WORD_ENTRY_ADDR);
  assign isQueryCmd = wrData[7:0] == CMD_QUERY;
  assign isResetCmd = wrData[7:0] == CMD_RESET;

  always_comb begin
    strb.enterQuery = wrEn && isQueryCmd && (addr == entryAddr);
    strb.leaveQuery = wrEn && isResetCmd;
  end

endmodule

// File: rtl/flash_query_dp.sv
module flash_query_dp
  import flash_query_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TABLE_DEPTH = 64,
  parameter int SIZE_LOG2   = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       arrayData,
  input  qmStrobe_t         strb,
  output logic              queryActive,
  output logic [15:0]       rdData
);

  localparam int IDX_W = $clog2(TABLE_DEPTH);

  logic [ADDR_W-1:0] tableIdx;
  logic              inRange;
  logic [7:0]        tableByte;

  // In byte mode the table sits at every other bus address.
  assign tableIdx  = byteMode ? {1'b0, addr[ADDR_W-1:1]} : addr;
  assign inRange   = (tableIdx >> IDX_W) == '0;
  assign tableByte = inRange ? queryByte(int'(tableIdx), SIZE_LOG2) : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                queryActive <= 1'b0;
    else if (strb.leaveQuery) queryActive <= 1'b0;
    else if (strb.enterQuery) queryActive <= 1'b1;
  end

  assign rdData = queryActive ? {8'h00, tableByte} : arrayData;

  // R9
  queryHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    queryActive && !strb.leaveQuery |=> queryActive);

  // R7
  outOfTable_chk: assert property (@(posedge clk) disable iff (!rstN)
    queryActive && (tableIdx >= ADDR_W'(TABLE_DEPTH)) |-> rdData == 16'h0000);

endmodule

// File: rtl/flash_query_mode.sv
module flash_query_mode
  import flash_query_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TABLE_DEPTH = 64,
  parameter int SIZE_LOG2   = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  input  logic [15:0]       arrayData,
  output logic              queryActive,
  output logic [15:0]       rdData
);

  qmStrobe_t strb;

  flash_query_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .byteMode (byteMode),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .strb     (strb)
  );

  flash_query_dp #(
    .ADDR_W      (ADDR_W),
    .TABLE_DEPTH (TABLE_DEPTH),
    .SIZE_LOG2   (SIZE_LOG2)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .byteMode    (byteMode),
    .addr        (addr),
    .arrayData   (arrayData),
    .strb        (strb),
    .queryActive (queryActive),
    .rdData      (rdData)
  );

  // R2
  wordEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !byteMode && wrData[7:0] == 8'h98 && addr == ADDR_W'(8'h55) |=> queryActive);

  // R3
  byteEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && byteMode && wrData[7:0] == 8'h98 && addr == ADDR_W'(8'hAA) |=> queryActive);

  // R8
  resetCmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[7:0] == 8'hF0 |=> !queryActive);

  // R5
  upperLane_chk: assert property (@(posedge clk) disable iff (!rstN)
    queryActive |-> rdData[15:8] == 8'h00);

  // R1
  passThrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    !queryActive |-> rdData == arrayData);

  // R11
  idleWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> queryActive == $past(queryActive));

endmodule

// File: tb/flash_query_mode_tb.sv
module flash_query_mode_tb;

  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              byteMode;
  logic              wrEn;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       wrData;
  logic [15:0]       arrayData;
  logic              queryActive;
  logic [15:0]       rdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_query_mode #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .arrayData(arrayData), .queryActive(queryActive), .rdData(rdData)
  );

  task automatic checkEq(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One qualified write; the mode flag has settled by the following falling edge.
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readAt(input logic [ADDR_W-1:0] a, input string req, input logic [15:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    checkEq(req, rdData, exp);
  endtask

  task automatic pulseReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    arrayData = 16'hBEEF;
    pulseReset();
    checkEq("R1 mode", {15'd0, queryActive}, 16'd0);
    readAt(8'h10, "R1 passthrough", 16'hBEEF);
  endtask

  task automatic testWrongAddr();
    byteMode = 1'b0;
    doWrite(8'hAA, 16'h0098);
    checkEq("R4 word AA", {15'd0, queryActive}, 16'd0);
    byteMode = 1'b1;
    doWrite(8'h55, 16'h0098);
    checkEq("R4 byte 55", {15'd0, queryActive}, 16'd0);
    byteMode = 1'b0;
    @(negedge clk);
    addr = 8'h55; wrData = 16'h0098; wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkEq("R11 no strobe", {15'd0, queryActive}, 16'd0);
  endtask

  task automatic testWordQuery();
    byteMode = 1'b0;
    arrayData = 16'hA5C3;
    doWrite(8'h55, 16'h0098);
    checkEq("R2 enter", {15'd0, queryActive}, 16'd1);
    readAt(8'h10, "R5 idx10", 16'h0051);
    readAt(8'h12, "R5 idx12", 16'h0059);
    readAt(8'h27, "R5 size", 16'h0016);
    readAt(8'h1C, "R5 vmax", 16'h0036);
    readAt(8'h3F, "R5 empty idx", 16'h0000);
    readAt(8'h80, "R7 beyond table", 16'h0000);
    doWrite(8'h55, 16'h1234);
    checkEq("R9 other write", {15'd0, queryActive}, 16'd1);
    doWrite(8'h10, 16'hFF98);
    checkEq("R9 repeat entry", {15'd0, queryActive}, 16'd1);
    doWrite(8'h03, 16'h00F0);
    checkEq("R8 exit", {15'd0, queryActive}, 16'd0);
    readAt(8'h10, "R8 array back", 16'hA5C3);
  endtask

  task automatic testByteQuery();
    byteMode = 1'b1;
    arrayData = 16'h7E81;
    doWrite(8'hAA, 16'h0098);
    checkEq("R3 enter", {15'd0, queryActive}, 16'd1);
    readAt(8'h20, "R6 even", 16'h0051);
    readAt(8'h21, "R6 odd", 16'h0051);
    readAt(8'h24, "R6 idx12", 16'h0059);
    readAt(8'h50, "R6 idx28", 16'h0002);
    readAt(8'hFE, "R7 byte beyond", 16'h0000);
  endtask

  task automatic testHwReset();
    pulseReset();
    checkEq("R10 reset exit", {15'd0, queryActive}, 16'd0);
    @(negedge clk);
    @(negedge clk);
    checkEq("R10 stays off", {15'd0, queryActive}, 16'd0);
    readAt(8'h20, "R10 array", 16'h7E81);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b1; byteMode = 1'b0; wrEn = 1'b0;
    addr = '0; wrData = '0; arrayData = '0;
    testReset();
    testWrongAddr();
    testWordQuery();
    testByteQuery();
    testHwReset();
    finish_run();
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule